// File: doc/BRIEF.md
# Serial FIFO Extension Interrupt Controller

This block sits next to a UART and serves as the host's control point for a pair of external FIFOs, one for transmit and one for receive. The host reaches it through a small byte-wide register window. Through that window it selects operating modes, chooses which interrupt sources may raise the interrupt line, reads a status byte, and resets both FIFOs. The FIFO storage, the UART core and the interval timer live outside the block. The block receives their fill-level flags, a receive character-timeout indication and the timer's interrupt request as inputs. It also sees the host's data-port traffic as two one-cycle event strobes: one for a push into the transmit FIFO and one for a pop from the receive FIFO.

There are five interrupt sources. Each has a pending bit that latches when its condition rises. Each pending bit is cleared by its own host side effect: a status read, a FIFO push or pop, a fill level crossing back, or switching the timer off. The enabled pending bits are combined into a single registered interrupt output. In level style the output stays high while anything enabled is pending. In edge style it gives one pulse each time the enabled set goes from empty to non-empty.

Top module: `sfx_irq_ctrl`

## Requirements
- R1: After reset the mode, enable, timer interval and timer control registers read 0, the interrupt output is 0 and no interrupt is pending. A source condition that is already true when reset is released does not latch.
- R2: Register map for reads and writes. Offset 0 is mode: bit4 selects the interrupt style (1 = level, 0 = edge), bit3 enables flow control, bit2 enables the FIFOs, bit0 swaps the halves, and bit1 always reads 0. Offset 1 is enable, with bit0 receive half, bit1 transmit below half, bit2 transmit empty, bit3 character timeout and bit4 timer. Offset 3 is an 8-bit timer interval. Offset 4 bit0 is timer enable. Offsets 5 to 7 read 0. Read data appears the cycle after the read strobe. The mode bits and timer fields drive the matching configuration outputs.
- R3: A read of offset 2 returns the following bits: bit7 timer pending, bit6 character-timeout pending, bit5 the inverse of rx_full, bit4 rx_half, bit3 rx_empty, bit2 tx_full, bit1 tx_half, bit0 tx_empty. The pending values returned are those from before any clear caused by that same read.
- R4: A write to offset 2 produces a one-cycle fifo_reset pulse in the cycle after the write, whatever the data, and changes no register.
- R5: A pending bit latches on the rising edge of its condition whether or not the source is enabled. The enable bits gate only the interrupt output. The conditions are timer_req, char_tmo, tx_empty, tx_half low (transmit drained below half) and rx_half.
- R6: Character-timeout pending clears on an rx_pop strobe or on a status read.
- R7: Transmit-empty pending clears on a tx_push strobe or on a status read.
- R8: Transmit-below-half pending clears on a status read, or when tx_half is seen high again.
- R9: Receive-half pending clears when rx_half is seen low. A status read leaves it set.
- R10: Timer pending clears only on a write of 0 to bit0 of offset 4. A status read or a write of 1 leaves it set.
- R11: When a rising condition and that source's clear event fall in the same cycle, the pending bit is set.
- R12: In level style the interrupt output equals, one cycle later, the OR of the enabled pending bits.
- R13: In edge style the interrupt output is high for exactly one cycle each time the OR of the enabled pending bits rises. It stays low while that OR remains high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid the cycle after reg_rd |
| tx_push | input | 1 | Host pushed a byte into the transmit FIFO |
| rx_pop | input | 1 | Host popped a byte from the receive FIFO |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_half | input | 1 | Transmit FIFO at or above half |
| tx_full | input | 1 | Transmit FIFO full |
| rx_empty | input | 1 | Receive FIFO empty |
| rx_half | input | 1 | Receive FIFO at or above half |
| rx_full | input | 1 | Receive FIFO full |
| char_tmo | input | 1 | Receive character-timeout indication |
| timer_req | input | 1 | Interval timer interrupt request |
| fifo_reset | output | 1 | One-cycle reset pulse to both FIFOs |
| cfg_flow_ctl | output | 1 | Automatic flow-control enable |
| cfg_fifo_en | output | 1 | External FIFO enable |
| cfg_half_swap | output | 1 | Swap the two 8-byte halves |
| tmr_interval | output | DATA_W | Timer interval value |
| tmr_enable | output | 1 | Timer enable |
| irq | output | 1 | Interrupt output |

## Verification
Each source is raised by itself with only that source enabled, and then retired in turn by every side effect that should clear it and by the side effects that should not, such as a status read for the receive-half and timer sources. This separates the five clear rules from one another. The same rising condition is run in level style and in edge style. Sustained pending must hold the line in level style, but it must produce one pulse and no more in edge style, including when a second rise arrives before any clear. A rise with the source masked, followed by a late enable, shows that latching and gating are independent. A rise that coincides with its own clear shows which of the two wins.

// File: rtl/sfx_pkg.sv
package sfx_pkg;
  // register offsets
  localparam int OFS_MODE = 0;
  localparam int OFS_IEN  = 1;
  localparam int OFS_STAT = 2;
  localparam int OFS_TVAL = 3;
  localparam int OFS_TCTL = 4;

  // mode register bit positions
  localparam int MB_LEVEL = 4;
  localparam int MB_FLOW  = 3;
  localparam int MB_FIFO  = 2;
  localparam int MB_SWAP  = 0;

  // interrupt source indices (equal to enable bit positions)
  localparam int SRC_RXH = 0;
  localparam int SRC_TXH = 1;
  localparam int SRC_TXE = 2;
  localparam int SRC_CTO = 3;
  localparam int SRC_TMR = 4;
  localparam int NUM_SRC = 5;

  typedef struct packed {
    logic level;
    logic flow;
    logic fifo_en;
    logic swap;
  } mode_t;
endpackage

// File: rtl/sfx_regs.sv
module sfx_regs
  import sfx_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  parameter int SRC_N  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] stat_in,
  output logic [DATA_W-1:0] rdata,
  output mode_t             mode,
  output logic [SRC_N-1:0]  ien,
  output logic [DATA_W-1:0] tval,
  output logic              ten,
  output logic              fifo_rst,
  output logic              stat_rd,
  output logic              tmr_off
);
  logic sel_mode, sel_ien, sel_stat, sel_tval, sel_tctl;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] mode_rd;

  assign sel_mode = (addr == ADDR_W'(OFS_MODE));
  assign sel_ien  = (addr == ADDR_W'(OFS_IEN));
  assign sel_stat = (addr == ADDR_W'(OFS_STAT));
  assign sel_tval = (addr == ADDR_W'(OFS_TVAL));
  assign sel_tctl = (addr == ADDR_W'(OFS_TCTL));

  assign stat_rd = rd && sel_stat;
  assign tmr_off = wr && sel_tctl && !wdata[0];

  always_comb begin
    mode_rd           = '0;
    mode_rd[MB_LEVEL] = mode.level;
    mode_rd[MB_FLOW]  = mode.flow;
    mode_rd[MB_FIFO]  = mode.fifo_en;
    mode_rd[MB_SWAP]  = mode.swap;
  end

  always_comb begin
    rd_mux = '0;
    if (sel_mode) rd_mux = mode_rd;
    if (sel_ien)  rd_mux[SRC_N-1:0] = ien;
    if (sel_stat) rd_mux = stat_in;
    if (sel_tval) rd_mux = tval;
    if (sel_tctl) rd_mux[0] = ten;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode     <= '0;
      ien      <= '0;
      tval     <= '0;
      ten      <= 1'b0;
      fifo_rst <= 1'b0;
      rdata    <= '0;
    end else begin
      fifo_rst <= wr && sel_stat;
      if (wr && sel_mode) begin
        mode.level   <= wdata[MB_LEVEL];
        mode.flow    <= wdata[MB_FLOW];
        mode.fifo_en <= wdata[MB_FIFO];
        mode.swap    <= wdata[MB_SWAP];
      end
      if (wr && sel_ien)  ien  <= wdata[SRC_N-1:0];
      if (wr && sel_tval) tval <= wdata;
      if (wr && sel_tctl) ten  <= wdata[0];
      if (rd) rdata <= rd_mux;
    end
  end

  AST_RSVD_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($past(rd && sel_mode) && !$past(rst)) |-> !rdata[1]); // R2
  AST_FRST_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    fifo_rst |-> $past(wr && sel_stat)); // R4
  AST_FRST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (fifo_rst && !(wr && sel_stat)) |=> !fifo_rst); // R4
endmodule

// File: rtl/sfx_src.sv
module sfx_src (
  input  logic clk,
  input  logic rst,
  input  logic cond,
  input  logic clr,
  output logic pend
);
  logic cond_q;

  always_ff @(posedge clk) begin
    cond_q <= cond;
    if (rst) begin
      pend <= 1'b0;
    end else if (cond && !cond_q) begin
      pend <= 1'b1;
    end else if (clr) begin
      pend <= 1'b0;
    end
  end

  AST_PEND_NEEDS_COND: assert property (@(posedge clk) disable iff (rst)
    $rose(pend) |-> $past(cond)); // R5
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(cond) && !$past(cond, 2) && $past(!rst, 2)) |-> pend); // R11
endmodule

// File: rtl/sfx_irq_out.sv
module sfx_irq_out #(
  parameter int SRC_N = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SRC_N-1:0] pend,
  input  logic [SRC_N-1:0] ien,
  input  logic             level,
  output logic             irq
);
  logic any_hit;
  logic any_q;

  assign any_hit = |(pend & ien);

  always_ff @(posedge clk) begin
    if (rst) begin
      any_q <= 1'b0;
      irq   <= 1'b0;
    end else begin
      any_q <= any_hit;
      irq   <= level ? any_hit : (any_hit && !any_q);
    end
  end

  AST_EDGE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    (irq && !level) |=> !irq); // R13
  AST_LEVEL_TRACKS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(level)) |-> (irq == $past(any_hit))); // R12
endmodule

// File: rtl/sfx_irq_ctrl.sv
module sfx_irq_ctrl
  import sfx_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              tx_push,
  input  logic              rx_pop,
  input  logic              tx_empty,
  input  logic              tx_half,
  input  logic              tx_full,
  input  logic              rx_empty,
  input  logic              rx_half,
  input  logic              rx_full,
  input  logic              char_tmo,
  input  logic              timer_req,
  output logic              fifo_reset,
  output logic              cfg_flow_ctl,
  output logic              cfg_fifo_en,
  output logic              cfg_half_swap,
  output logic [DATA_W-1:0] tmr_interval,
  output logic              tmr_enable,
  output logic              irq
);
  mode_t              mode;
  logic [NUM_SRC-1:0] ien;
  logic [NUM_SRC-1:0] cond;
  logic [NUM_SRC-1:0] clr;
  logic [NUM_SRC-1:0] pend;
  logic [DATA_W-1:0]  stat;
  logic               stat_rd;
  logic               tmr_off;

  always_comb begin
    stat    = '0;
    stat[7] = pend[SRC_TMR];
    stat[6] = pend[SRC_CTO];
    stat[5] = !rx_full;
    stat[4] = rx_half;
    stat[3] = rx_empty;
    stat[2] = tx_full;
    stat[1] = tx_half;
    stat[0] = tx_empty;
  end

  always_comb begin
    cond          = '0;
    cond[SRC_RXH] = rx_half;
    cond[SRC_TXH] = !tx_half;
    cond[SRC_TXE] = tx_empty;
    cond[SRC_CTO] = char_tmo;
    cond[SRC_TMR] = timer_req;
    clr           = '0;
    clr[SRC_RXH]  = !rx_half;
    clr[SRC_TXH]  = tx_half || stat_rd;
    clr[SRC_TXE]  = tx_push || stat_rd;
    clr[SRC_CTO]  = rx_pop || stat_rd;
    clr[SRC_TMR]  = tmr_off;
  end

  sfx_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SRC_N(NUM_SRC)) u_regs (
    .clk(clk), .rst(rst), .addr(reg_addr), .wr(reg_wr), .rd(reg_rd),
    .wdata(reg_wdata), .stat_in(stat), .rdata(reg_rdata), .mode(mode),
    .ien(ien), .tval(tmr_interval), .ten(tmr_enable), .fifo_rst(fifo_reset),
    .stat_rd(stat_rd), .tmr_off(tmr_off)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    sfx_src u_src (
      .clk(clk), .rst(rst), .cond(cond[g]), .clr(clr[g]), .pend(pend[g])
    );
  end

  sfx_irq_out #(.SRC_N(NUM_SRC)) u_out (
    .clk(clk), .rst(rst), .pend(pend), .ien(ien), .level(mode.level), .irq(irq)
  );

  assign cfg_flow_ctl  = mode.flow;
  assign cfg_fifo_en   = mode.fifo_en;
  assign cfg_half_swap = mode.swap;

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|ien)); // R5
  AST_CTO_CLEARED: assert property (@(posedge clk) disable iff (rst)
    ((stat_rd || rx_pop) && !char_tmo) |=> !pend[SRC_CTO]); // R6
  AST_TXE_CLEARED: assert property (@(posedge clk) disable iff (rst)
    ((stat_rd || tx_push) && !tx_empty) |=> !pend[SRC_TXE]); // R7
  AST_RXH_DROPS: assert property (@(posedge clk) disable iff (rst)
    !rx_half |=> !pend[SRC_RXH]); // R9
endmodule

// File: tb/test_sfx_irq_ctrl.sv
module test_sfx_irq_ctrl;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic tx_push = 0, rx_pop = 0, tx_empty = 0, tx_half = 0, tx_full = 0;
  logic rx_empty = 0, rx_half = 0, rx_full = 0, char_tmo = 0, timer_req = 0;
  logic fifo_reset, cfg_flow_ctl, cfg_fifo_en, cfg_half_swap, tmr_enable, irq;
  logic [DATA_W-1:0] tmr_interval;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sfx_irq_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_sfx_irq_ctrl (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_push(tx_push),
    .rx_pop(rx_pop), .tx_empty(tx_empty), .tx_half(tx_half), .tx_full(tx_full),
    .rx_empty(rx_empty), .rx_half(rx_half), .rx_full(rx_full),
    .char_tmo(char_tmo), .timer_req(timer_req), .fifo_reset(fifo_reset),
    .cfg_flow_ctl(cfg_flow_ctl), .cfg_fifo_en(cfg_fifo_en),
    .cfg_half_swap(cfg_half_swap), .tmr_interval(tmr_interval),
    .tmr_enable(tmr_enable), .irq(irq)
  );

  // {offset, write data, expected readback}
  localparam logic [23:0] VEC [10] = '{
    {8'd0, 8'hFF, 8'h1D}, {8'd0, 8'h12, 8'h10}, {8'd1, 8'hFF, 8'h1F},
    {8'd1, 8'h0A, 8'h0A}, {8'd3, 8'hA5, 8'hA5}, {8'd3, 8'h01, 8'h01},
    {8'd4, 8'hFF, 8'h01}, {8'd4, 8'h00, 8'h00}, {8'd5, 8'h77, 8'h00},
    {8'd7, 8'hFF, 8'h00}
  };

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, logic [7:0] d);
    reg_addr = ADDR_W'(a); reg_wdata = d; reg_wr = 1'b1;
    cyc(1);
    reg_wr = 1'b0;
  endtask

  task automatic rd(int a, output logic [7:0] d);
    reg_addr = ADDR_W'(a); reg_rd = 1'b1;
    cyc(1);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  // count irq high cycles over a window
  task automatic irq_count(int n, output int cnt);
    cnt = 0;
    for (int k = 0; k < n; k++) begin
      cyc(1);
      if (irq) cnt++;
    end
  endtask

  initial begin
    logic [7:0] d;
    int cnt;
    cyc(3);
    rst = 1'b0;
    cyc(1);

    // R1 reset state
    check("R1 irq", {7'b0, irq}, 8'h00);
    for (int a = 0; a < 5; a++) begin
      if (a == 2) continue;
      rd(a, d);
      check("R1 reg", d, 8'h00);
    end
    rd(2, d);
    check("R1 status", d, 8'h20);

    // R2 register table
    for (int i = 0; i < 10; i++) begin
      wr(int'(VEC[i][23:16]), VEC[i][15:8]);
      rd(int'(VEC[i][23:16]), d);
      check("R2 readback", d, VEC[i][7:0]);
    end
    wr(0, 8'h0D);
    check("R2 cfg outputs", {5'b0, cfg_flow_ctl, cfg_fifo_en, cfg_half_swap}, 8'h07);
    wr(3, 8'h3C); wr(4, 8'h01);
    check("R2 timer outputs", tmr_interval, 8'h3C);
    check("R2 timer enable", {7'b0, tmr_enable}, 8'h01);

    // R4 fifo reset pulse
    check("R4 idle", {7'b0, fifo_reset}, 8'h00);
    wr(2, 8'h00);
    check("R4 pulse", {7'b0, fifo_reset}, 8'h01);
    cyc(1);
    check("R4 single", {7'b0, fifo_reset}, 8'h00);
    rd(0, d);
    check("R4 mode kept", d, 8'h0D);

    // R3 status layout
    rx_full = 1; rx_half = 1; tx_full = 1; tx_half = 1;
    cyc(1);
    rd(2, d);
    check("R3 layout", d, 8'h16);
    rx_full = 0; rx_half = 0; tx_full = 0; tx_half = 0; rx_empty = 1;
    cyc(1);
    rd(2, d);
    check("R3 layout2", d, 8'h28);
    rx_empty = 0;

    // R5 latch while masked, gate on enable
    wr(4, 8'h00);
    wr(0, 8'h10);
    wr(1, 8'h00);
    rd(2, d);
    char_tmo = 1; cyc(1); char_tmo = 0;
    cyc(3);
    check("R5 masked irq", {7'b0, irq}, 8'h00);
    wr(1, 8'h08);
    cyc(1);
    check("R5 late enable", {7'b0, irq}, 8'h01);
    rd(2, d);
    check("R3 pending before clear", d & 8'h40, 8'h40);
    cyc(1);
    check("R6 status read clears", {7'b0, irq}, 8'h00);

    // R12 level + R6 rx_pop clear
    char_tmo = 1; cyc(1); char_tmo = 0;
    cyc(1);
    check("R12 level rise", {7'b0, irq}, 8'h01);
    cyc(3);
    check("R12 level hold", {7'b0, irq}, 8'h01);
    rx_pop = 1; cyc(1); rx_pop = 0;
    cyc(1);
    check("R6 rx_pop clears", {7'b0, irq}, 8'h00);
    rd(2, d);
    check("R6 status bit", d & 8'h40, 8'h00);

    // R7 tx empty
    wr(1, 8'h04);
    tx_empty = 1; cyc(2);
    check("R7 set", {7'b0, irq}, 8'h01);
    tx_push = 1; cyc(1); tx_push = 0;
    cyc(1);
    check("R7 push clears", {7'b0, irq}, 8'h00);
    tx_empty = 0; cyc(1); tx_empty = 1; cyc(2);
    check("R7 set again", {7'b0, irq}, 8'h01);
    rd(2, d); cyc(1);
    check("R7 read clears", {7'b0, irq}, 8'h00);

    // R11 set beats clear
    tx_empty = 0; cyc(1);
    tx_empty = 1; tx_push = 1; cyc(1); tx_push = 0;
    cyc(1);
    check("R11 set wins", {7'b0, irq}, 8'h01);
    rd(2, d); cyc(1);
    tx_empty = 0;

    // R8 transmit below half
    wr(1, 8'h02);
    rd(2, d);
    tx_half = 1; cyc(1); tx_half = 0; cyc(2);
    check("R8 set", {7'b0, irq}, 8'h01);
    tx_half = 1; cyc(2);
    check("R8 refill clears", {7'b0, irq}, 8'h00);
    tx_half = 0; cyc(2);
    check("R8 set again", {7'b0, irq}, 8'h01);
    rd(2, d); cyc(1);
    check("R8 read clears", {7'b0, irq}, 8'h00);

    // R9 receive half
    wr(1, 8'h01);
    rx_half = 1; cyc(2);
    check("R9 set", {7'b0, irq}, 8'h01);
    rd(2, d); cyc(2);
    check("R9 read ignored", {7'b0, irq}, 8'h01);
    rx_half = 0; cyc(2);
    check("R9 drain clears", {7'b0, irq}, 8'h00);

    // R10 timer
    wr(1, 8'h10);
    timer_req = 1; cyc(1); timer_req = 0; cyc(1);
    check("R10 set", {7'b0, irq}, 8'h01);
    rd(2, d); cyc(1);
    check("R10 status bit", d & 8'h80, 8'h80);
    check("R10 read ignored", {7'b0, irq}, 8'h01);
    wr(4, 8'h01); cyc(1);
    check("R10 enable write ignored", {7'b0, irq}, 8'h01);
    wr(4, 8'h00); cyc(1);
    check("R10 disable clears", {7'b0, irq}, 8'h00);

    // R13 edge style
    wr(0, 8'h00);
    wr(1, 8'h08);
    rd(2, d);
    char_tmo = 1; cyc(1); char_tmo = 0;
    check("R13 not early", {7'b0, irq}, 8'h00);
    irq_count(6, cnt);
    check("R13 one pulse", 8'(cnt), 8'd1);
    char_tmo = 1; cyc(1); char_tmo = 0;
    irq_count(6, cnt);
    check("R13 no repulse while pending", 8'(cnt), 8'd0);
    rd(2, d);
    char_tmo = 1; cyc(1); char_tmo = 0;
    irq_count(6, cnt);
    check("R13 pulse after clear", 8'(cnt), 8'd1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule